// File: doc/BRIEF.md
# Flash command state machine

This block is the device-side command decoder of a small parallel NOR-style flash model. A host drives byte writes and byte reads over a synchronous address/data bus. Written command bytes choose what a read returns: the stored array byte, an identification and lock-configuration view, or the status register. Three operations that change the array or its protection need a two-byte write sequence: block erase, byte program and clearing of the block lock bits. While an operation runs, the block reports busy through the status register and ignores further writes.

The storage is an on-chip byte array that starts fully erased (every byte 0xFF). Each block has a lock bit, and the device has one master lock bit. Both come from parameters at reset. The master lock can stop the lock bits from being cleared. Erase sweeps the block one byte per cycle. Program is a read-modify-write that can only clear bits. A run timer holds the busy state for a set number of cycles.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in array mode, all error flags are clear and a status read returns 0x80. Every array byte reads 0xFF until it is programmed.
- R2: Writing 0xFF selects array mode from any mode. A read sampled on one clock edge returns its byte on `rdata` after that edge.
- R3: After a write of 0x90, the block offset 0 returns MFG_CODE and the offset (1 << ADDR_SHIFT) returns DEV_CODE. Offsets not listed in R3 or R4 return 0x00.
- R4: In the identification mode, the offset (2 << ADDR_SHIFT) in any block returns that block's lock bit in bit 0. The offset (3 << ADDR_SHIFT) returns the master lock bit in bit 0.
- R5: Writing 0x70 selects status mode. The status byte carries ready in bit 7 (1 = ready), the erase error in bit 5, the program error in bit 4 and the lock refusal in bit 1. Bits 6, 3, 2 and 0 read 0.
- R6: Writing 0x50 clears status bits 5, 4 and 1 and leaves the read mode unchanged.
- R7: Writing 0x40 and then a data byte to an address in an unlocked block stores the bitwise AND of the data and the old byte. Bit 7 reads 0 for exactly BUSY_CYCLES status reads after the data write.
- R8: Writing 0x20 and then 0xD0 to an address in an unlocked block sets all bytes of that block to 0xFF. Bit 7 reads 0 for exactly max(BUSY_CYCLES, block size) status reads.
- R9: A program or erase aimed at a locked block does not start. It sets bits 1 and 4 (program) or bits 1 and 5 (erase) and leaves the array unchanged.
- R10: If the second byte of an erase or lock-clear sequence is not 0xD0, bits 4 and 5 are set and nothing is changed.
- R11: Writing 0x60 and then 0xD0 clears all block lock bits, busy for BUSY_CYCLES reads, if the master lock is 0. If the master lock is 1, it sets bits 1 and 5 and the lock bits are kept.
- R12: While busy, writes have no effect on mode, errors, locks or the array.
- R13: The first byte of a two-byte sequence switches reads to status mode, and so does its completion. An unknown command byte leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Read data, valid after the edge that sampled `rd_en` |

## Verification
A read takes one edge to produce its result: the value on `rdata` is sampled at the falling edge that follows the rising edge that took `rd_en`. The bench issues one bus operation per cycle, so status polling that starts right after a confirming write counts the busy reads exactly. That count is compared with BUSY_CYCLES, or with the block size for an erase, and a refused operation must show zero busy reads. Error flags are checked at the first status read after the sequence.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_IDENT, MODE_STATUS} mode_e;
  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG, OP_UNLOCK} op_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLRSR   = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_UNLOCK  = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam int SB_READY = 7;
  localparam int SB_EERR  = 5;
  localparam int SB_PERR  = 4;
  localparam int SB_LOCK  = 1;
endpackage

// File: rtl/flcmd_array.sv
module flcmd_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // factory state: fully erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 6,
  localparam int NBLK  = 1 << (ADDR_W - BLK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic [NBLK-1:0]   lock_vec,
  input  logic              master_lock,
  output mode_e             mode,
  output logic              start,
  output op_e               start_op,
  output logic [ADDR_W-1:0] start_addr,
  output logic [7:0]        start_data,
  output logic              err_erase,
  output logic              err_prog,
  output logic              err_lock
);
  op_e   pend, nxt_pend;
  mode_e nxt_mode;
  logic  go, set_ee, set_ep, set_el, clr;
  logic  blk_locked;
  logic  accept;

  assign blk_locked = lock_vec[addr[ADDR_W-1:BLK_W]];
  assign accept     = wr_en && !busy;

  always_comb begin
    go       = 1'b0;
    set_ee   = 1'b0;
    set_ep   = 1'b0;
    set_el   = 1'b0;
    clr      = 1'b0;
    nxt_mode = mode;
    nxt_pend = pend;
    if (accept) begin
      if (pend != OP_NONE) begin
        nxt_pend = OP_NONE;
        nxt_mode = MODE_STATUS;
        case (pend)
          OP_ERASE: begin
            if (wdata != CMD_CONFIRM) begin
              set_ee = 1'b1; set_ep = 1'b1;
            end else if (blk_locked) begin
              set_ee = 1'b1; set_el = 1'b1;
            end else begin
              go = 1'b1;
            end
          end
          OP_PROG: begin
            if (blk_locked) begin
              set_ep = 1'b1; set_el = 1'b1;
            end else begin
              go = 1'b1;
            end
          end
          OP_UNLOCK: begin
            if (wdata != CMD_CONFIRM) begin
              set_ee = 1'b1; set_ep = 1'b1;
            end else if (master_lock) begin
              set_ee = 1'b1; set_el = 1'b1;
            end else begin
              go = 1'b1;
            end
          end
          default: ;
        endcase
      end else begin
        case (wdata)
          CMD_ARRAY:  nxt_mode = MODE_ARRAY;
          CMD_IDENT:  nxt_mode = MODE_IDENT;
          CMD_STATUS: nxt_mode = MODE_STATUS;
          CMD_CLRSR:  clr = 1'b1;
          CMD_ERASE:  begin nxt_pend = OP_ERASE;  nxt_mode = MODE_STATUS; end
          CMD_PROG:   begin nxt_pend = OP_PROG;   nxt_mode = MODE_STATUS; end
          CMD_UNLOCK: begin nxt_pend = OP_UNLOCK; nxt_mode = MODE_STATUS; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_ARRAY;
      pend      <= OP_NONE;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_lock  <= 1'b0;
    end else begin
      mode      <= nxt_mode;
      pend      <= nxt_pend;
      err_erase <= !clr && (err_erase || set_ee);
      err_prog  <= !clr && (err_prog  || set_ep);
      err_lock  <= !clr && (err_lock  || set_el);
    end
  end

  assign start      = go;
  assign start_op   = pend;
  assign start_addr = addr;
  assign start_data = wdata;

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start); // R12
  AST_SEQ_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (accept && pend != OP_NONE) |=> mode == MODE_STATUS); // R13
  AST_CLR_ERRS: assert property (@(posedge clk) disable iff (rst)
    (accept && pend == OP_NONE && wdata == CMD_CLRSR) |=> !(err_erase || err_prog || err_lock)); // R6
endmodule

// File: rtl/flcmd_engine.sv
module flcmd_engine
  import flcmd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          BLK_W       = 6,
  parameter int          BUSY_CYCLES = 6,
  parameter logic [31:0] LOCK_INIT   = 32'h0,
  parameter bit          MASTER_LOCK = 1'b0,
  localparam int NBLK      = 1 << (ADDR_W - BLK_W),
  localparam int BLK_BYTES = 1 << BLK_W,
  localparam int ERASE_LEN = (BUSY_CYCLES > BLK_BYTES) ? BUSY_CYCLES : BLK_BYTES,
  localparam int TW        = $clog2(ERASE_LEN + 1),
  localparam int IW        = BLK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_e               start_op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  input  logic [7:0]        ram_q,
  output logic              busy,
  output logic [ADDR_W-1:0] eng_raddr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic [NBLK-1:0]   lock_vec,
  output logic              master_lock
);
  logic [TW-1:0]     timer;
  logic [IW-1:0]     idx;
  op_e               cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer    <= '0;
      idx      <= '0;
      cur_op   <= OP_NONE;
      cur_addr <= '0;
      cur_data <= '0;
      lock_vec <= LOCK_INIT[NBLK-1:0];
    end else if (start) begin
      timer    <= (start_op == OP_ERASE) ? TW'(ERASE_LEN) : TW'(BUSY_CYCLES);
      idx      <= '0;
      cur_op   <= start_op;
      cur_addr <= start_addr;
      cur_data <= start_data;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
      idx   <= idx + 1'b1;
      if (cur_op == OP_UNLOCK && timer == TW'(1)) lock_vec <= '0;
    end
  end

  assign busy        = (timer != '0);
  assign master_lock = MASTER_LOCK;
  assign eng_raddr   = cur_addr;

  // erase: one byte per busy cycle; program: read at idx 0, write at idx 1
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = cur_addr;
    ram_wdata = ram_q & cur_data;
    if (busy) begin
      if (cur_op == OP_ERASE) begin
        ram_we    = (idx < IW'(BLK_BYTES));
        ram_waddr = {cur_addr[ADDR_W-1:BLK_W], idx[BLK_W-1:0]};
        ram_wdata = 8'hFF;
      end else if (cur_op == OP_PROG) begin
        ram_we = (idx == IW'(1));
      end
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R7
  AST_LOCK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (lock_vec & ~$past(lock_vec)) == '0); // R11
  AST_LOCK_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (lock_vec != $past(lock_vec)) |-> $past(cur_op) == OP_UNLOCK); // R11
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flcmd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          BLK_W       = 6,
  parameter int          BUSY_CYCLES = 6,
  parameter int          ADDR_SHIFT  = 0,
  parameter logic [7:0]  MFG_CODE    = 8'h5B,
  parameter logic [7:0]  DEV_CODE    = 8'hE4,
  parameter logic [31:0] LOCK_INIT   = 32'h4,
  parameter bit          MASTER_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int NBLK = 1 << (ADDR_W - BLK_W);
  localparam logic [BLK_W-1:0] OFF_MFG  = BLK_W'(0);
  localparam logic [BLK_W-1:0] OFF_DEV  = BLK_W'(1 << ADDR_SHIFT);
  localparam logic [BLK_W-1:0] OFF_BLK  = BLK_W'(2 << ADDR_SHIFT);
  localparam logic [BLK_W-1:0] OFF_MSTR = BLK_W'(3 << ADDR_SHIFT);

  mode_e             mode;
  logic              start, busy, ram_we, master_lock;
  op_e               start_op;
  logic [ADDR_W-1:0] start_addr, eng_raddr, ram_waddr, ram_raddr;
  logic [7:0]        start_data, ram_wdata, ram_q;
  logic [NBLK-1:0]   lock_vec;
  logic              err_erase, err_prog, err_lock;
  logic [7:0]        status_val, ident_val, aux_q;
  logic              sel_array_q;

  flcmd_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
    .clk, .rst, .wr_en, .addr, .wdata, .busy, .lock_vec, .master_lock,
    .mode, .start, .start_op, .start_addr, .start_data,
    .err_erase, .err_prog, .err_lock
  );

  flcmd_engine #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYCLES(BUSY_CYCLES),
    .LOCK_INIT(LOCK_INIT), .MASTER_LOCK(MASTER_LOCK)
  ) u_eng (
    .clk, .rst, .start, .start_op, .start_addr, .start_data, .ram_q,
    .busy, .eng_raddr, .ram_we, .ram_waddr, .ram_wdata, .lock_vec, .master_lock
  );

  assign ram_raddr = busy ? eng_raddr : addr;

  flcmd_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk, .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(rd_en || busy), .raddr(ram_raddr), .q(ram_q)
  );

  always_comb begin
    status_val           = 8'h00;
    status_val[SB_READY] = !busy;
    status_val[SB_EERR]  = err_erase;
    status_val[SB_PERR]  = err_prog;
    status_val[SB_LOCK]  = err_lock;
  end

  always_comb begin
    unique case (addr[BLK_W-1:0])
      OFF_MFG:  ident_val = MFG_CODE;
      OFF_DEV:  ident_val = DEV_CODE;
      OFF_BLK:  ident_val = {7'b0, lock_vec[addr[ADDR_W-1:BLK_W]]};
      OFF_MSTR: ident_val = {7'b0, master_lock};
      default:  ident_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_array_q <= 1'b0;
      aux_q       <= 8'h00;
    end else if (rd_en) begin
      sel_array_q <= (mode == MODE_ARRAY);
      aux_q       <= (mode == MODE_IDENT) ? ident_val : status_val;
    end
  end

  assign rdata = sel_array_q ? ram_q : aux_q;

  AST_BUSY_STATUS_MODE: assert property (@(posedge clk) disable iff (rst)
    busy |-> mode == MODE_STATUS); // R7
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy); // R12
endmodule

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;
  localparam int ADDR_W = 8;
  localparam int BLK_W  = 6;
  localparam int BUSY   = 6;
  localparam int ELEN   = 64;
  localparam logic [7:0] MFG = 8'h5B;
  localparam logic [7:0] DEV = 8'hE4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, sel2 = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata1, rdata2, rv;
  int n_chk = 0, n_bad = 0, cnt;
  bit done = 0;

  logic [7:0] mdl [256];
  logic [3:0] mlock;
  bit ee, ep, el;

  always #5 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYCLES(BUSY), .ADDR_SHIFT(0),
    .MFG_CODE(MFG), .DEV_CODE(DEV), .LOCK_INIT(32'h4), .MASTER_LOCK(1'b0)) u_dut (
    .clk, .rst, .wr_en(wr_en && !sel2), .rd_en(rd_en && !sel2), .addr, .wdata, .rdata(rdata1));

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYCLES(BUSY), .ADDR_SHIFT(1),
    .MFG_CODE(MFG), .DEV_CODE(DEV), .LOCK_INIT(32'h1), .MASTER_LOCK(1'b1)) u_dut_ml (
    .clk, .rst, .wr_en(wr_en && sel2), .rd_en(rd_en && sel2), .addr, .wdata, .rdata(rdata2));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  // every task starts and ends at a falling edge: one bus operation per cycle
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = sel2 ? rdata2 : rdata1;
  endtask

  task automatic wait_ready(output int n, output logic [7:0] st);
    n = 0;
    rd(8'h00, st);
    while (!st[7] && n < 400) begin
      n++;
      rd(8'h00, st);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {1'b1, 1'b0, ee, ep, 1'b0, 1'b0, el, 1'b0};
  endfunction

  function automatic logic [7:0] exp_id(input logic [7:0] a);
    case (a[5:0])
      6'd0: return MFG;
      6'd1: return DEV;
      6'd2: return {7'b0, mlock[a[7:6]]};
      6'd3: return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_prog(input string req, input logic [7:0] a, input logic [7:0] d);
    wr(8'h00, 8'h40);
    wr(a, d);
    wait_ready(cnt, rv);
    if (mlock[a[7:6]]) begin ep = 1; el = 1; chk({req, " R9 no busy"}, cnt, 0); end
    else begin mdl[a] = mdl[a] & d; chk({req, " R7 busy"}, cnt, BUSY); end
    chk({req, " status"}, rv, exp_status());
  endtask

  task automatic do_erase(input string req, input logic [7:0] a);
    wr(a, 8'h20);
    wr(a, 8'hD0);
    wait_ready(cnt, rv);
    if (mlock[a[7:6]]) begin ee = 1; el = 1; chk({req, " R9 no busy"}, cnt, 0); end
    else begin
      for (int i = 0; i < 64; i++) mdl[{a[7:6], 6'(i)}] = 8'hFF;
      chk({req, " R8 busy"}, cnt, ELEN);
    end
    chk({req, " status"}, rv, exp_status());
  endtask

  task automatic rd_array(input string req, input logic [7:0] a);
    wr(8'h00, 8'hFF);
    rd(a, rv);
    chk(req, rv, mdl[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    mlock = 4'b0100; ee = 0; ep = 0; el = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state and R2 array read
    rd(8'h10, rv); chk("R1 erased array after reset", rv, 8'hFF);
    wr(8'h00, 8'h70); rd(8'h00, rv); chk("R1 R5 status after reset", rv, 8'h80);

    // R3, R4 identification view
    wr(8'h00, 8'h90);
    rd(8'h00, rv); chk("R3 mfg code", rv, MFG);
    rd(8'h41, rv); chk("R3 dev code in block 1", rv, DEV);
    rd(8'h05, rv); chk("R3 other offset", rv, 8'h00);
    rd(8'h42, rv); chk("R4 block 1 unlocked", rv, 8'h00);
    rd(8'h82, rv); chk("R4 block 2 locked", rv, 8'h01);
    rd(8'h03, rv); chk("R4 master lock", rv, 8'h00);

    // R7 program with AND
    do_prog("R7 first", 8'h05, 8'h5A);
    rd_array("R2 R7 read back", 8'h05);
    do_prog("R7 and", 8'h05, 8'h0F);
    rd_array("R7 and result", 8'h05);
    chk("R7 and literal", rv, 8'h0A);

    // R12 writes during busy are ignored
    wr(8'h00, 8'h40); wr(8'h06, 8'h33);
    wr(8'h00, 8'hFF); wr(8'h00, 8'h90);
    rd(8'h00, rv); chk("R12 still status and busy", rv, 8'h00);
    wait_ready(cnt, rv); mdl[8'h06] = 8'h33;
    chk("R12 ready after op", rv, 8'h80);
    rd_array("R12 data stored", 8'h06);

    // R9 locked program / erase, R6 clear keeps status mode
    do_prog("R9 locked prog", 8'h85, 8'h00);
    chk("R9 prog status literal", rv, 8'h92);
    rd_array("R9 array unchanged", 8'h85);
    wr(8'h00, 8'h70); wr(8'h00, 8'h50); ee = 0; ep = 0; el = 0;
    rd(8'h00, rv); chk("R6 cleared, still status", rv, 8'h80);
    do_erase("R9 locked erase", 8'h90);
    chk("R9 erase status literal", rv, 8'hA2);
    wr(8'h00, 8'h50); ee = 0; el = 0;

    // R10 bad confirm bytes
    wr(8'h00, 8'h20); wr(8'h00, 8'h11); rd(8'h00, rv);
    chk("R10 erase bad confirm", rv, 8'hB0);
    rd_array("R10 array unchanged", 8'h05);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h60); wr(8'h00, 8'h00); rd(8'h00, rv);
    chk("R10 unlock bad confirm", rv, 8'hB0);
    wr(8'h00, 8'h90); rd(8'h82, rv); chk("R10 lock kept", rv, 8'h01);
    wr(8'h00, 8'h50);

    // R8 erase
    do_erase("R8 erase block 0", 8'h07);
    rd_array("R8 byte erased", 8'h05);
    chk("R8 literal", rv, 8'hFF);
    rd_array("R8 last byte", 8'h3F);

    // R13 first byte selects status; unknown byte keeps mode
    wr(8'h00, 8'hFF); wr(8'h00, 8'h40); rd(8'h10, rv);
    chk("R13 status after first byte", rv, 8'h80);
    wr(8'h10, 8'h77); wait_ready(cnt, rv); mdl[8'h10] = 8'h77;
    chk("R13 R7 busy", cnt, BUSY);
    wr(8'h00, 8'hFF); wr(8'h00, 8'h33); rd(8'h10, rv);
    chk("R13 unknown command ignored", rv, 8'h77);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int k;
      logic [7:0] a;
      k = $urandom_range(0, 39);
      a = 8'($urandom);
      if (k < 14) do_prog("R7 R9 random prog", a, 8'($urandom));
      else if (k < 24) rd_array("R2 random read", a);
      else if (k < 30) begin
        a[5:2] = 4'h0;
        wr(8'h00, 8'h90); rd(a, rv); chk("R3 R4 random ident", rv, exp_id(a));
      end else if (k < 36) begin
        wr(8'h00, 8'h70); rd(a, rv); chk("R5 random status", rv, exp_status());
      end else if (k < 38) begin
        wr(8'h00, 8'h50); ee = 0; ep = 0; el = 0;
      end else do_erase("R8 R9 random erase", a);
    end

    // R11 lock clear with master lock off
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0); wait_ready(cnt, rv);
    chk("R11 unlock busy", cnt, BUSY);
    mlock = 4'b0000;
    wr(8'h00, 8'h90); rd(8'h82, rv); chk("R11 block 2 unlocked", rv, 8'h00);
    do_prog("R11 program after unlock", 8'h85, 8'h3C);
    rd_array("R11 programmed", 8'h85);

    // second instance: master lock set, shifted identification offsets
    sel2 = 1'b1;
    @(negedge clk);
    wr(8'h00, 8'h90);
    rd(8'h00, rv); chk("R3 shifted mfg", rv, MFG);
    rd(8'h02, rv); chk("R3 shifted dev", rv, DEV);
    rd(8'h01, rv); chk("R3 shifted odd offset", rv, 8'h00);
    rd(8'h04, rv); chk("R4 shifted block lock", rv, 8'h01);
    rd(8'h06, rv); chk("R4 shifted master lock", rv, 8'h01);
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0); wait_ready(cnt, rv);
    chk("R11 master refuse no busy", cnt, 0);
    chk("R11 master refuse status", rv, 8'hA2);
    wr(8'h00, 8'h90); rd(8'h04, rv); chk("R11 lock kept", rv, 8'h01);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule